// File: doc/BRIEF.md
# Master Interrupt Aggregator

This block sits at the top of a two-level interrupt tree. The graphics engines report through 32-bit identity words. Each word is shared by two engines: one uses the low 16 bits and the other uses the high 16 bits. The block reduces each half to a single per-engine summary bit. The display pipes, the display port unit, the display miscellaneous unit, the south-bridge unit and the power unit each report on one summary line. All of these summaries are gathered into one 32-bit master register, and the host interrupt line is driven from that register.

Bit 31 of the master register is a global enable that software writes. Every other bit is read-only status. A service routine reads the register to learn which unit needs attention. It then writes 0 to drop the host line while it services the sub-units, and writes bit 31 back when it is done. Source bits are level-based copies of their inputs, so an event that is still pending when the enable returns raises the line again and is not lost.

Top module: `irq_master_agg`

## Requirements
- R1: After reset, the master register reads 0x00000000 and `host_irq` is low.
- R2: A write sets the enable (bit 31) to bit 31 of the written data. The new value reads back after the clock edge that accepts the write. Without a write, the enable holds its value.
- R3: `host_irq` is high exactly when the enable is 1 and at least one of bits 30:0 of the master register is 1.
- R4: Master bit 2*w+h is the OR of half h of engine word w, where half 0 is bits 15:0 and half 1 is bits 31:16. With the default four words this gives: word 0 low (render) at bit 0, word 0 high (blitter) at bit 1, word 1 low (first video) at bit 2, word 1 high (second video) at bit 3, word 2 halves at bits 4 and 5, word 3 low (video enhancement) at bit 6, and word 3 high at bit 7.
- R5: Display pipe p appears at master bit 16+p, for pipes 0 to 2. The display port line appears at bit 20, the display misc line at bit 22, and the south-bridge line at bit 23.
- R6: The power-unit line appears at master bit 30.
- R7: Writes have no effect on bits 30:0. Writing 0x7FFFFFFF leaves the enable at 0 and leaves the source bits unchanged.
- R8: Bits 8 to 15, 19, 21 and 24 to 29 always read 0, even when every input is driven high.
- R9: A source bit follows its input with one register stage. It shows the input value sampled at a clock edge right after that edge, and not before it.
- R10: Writing 0 drops `host_irq` after the accepting edge while pending source bits stay visible. Writing 0x80000000 with a source still pending raises `host_irq` again after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| eng_words | input | ENG_WORDS*2*HALF_W (128) | Engine identity words; word w occupies bits [32w+31:32w] |
| pipe_irq | input | NUM_PIPES (3) | Per-pipe display summary lines |
| port_irq | input | 1 | Display port unit summary |
| misc_irq | input | 1 | Display misc unit summary |
| south_irq | input | 1 | South-bridge unit summary |
| power_irq | input | 1 | Power unit summary |
| reg_we | input | 1 | Master register write strobe |
| reg_wdata | input | 32 | Master register write data |
| reg_rdata | output | 32 | Master register read value |
| host_irq | output | 1 | Interrupt line to the host |

## Verification
The bench builds the block with its default parameters: four engine words of two 16-bit halves each and three display pipes. With these values, every bit of the 8-bit engine field can be reached, including the two halves of word 2 and the high half of word 3, which carry no named engine. All three pipe bits can also be reached, so the bench sweeps each source position on its own and then drives all inputs high at once to confirm the zero-reading bits. These parameters also let the bench drive a source bit at the top and at the bottom of each half, which tests the split between the two halves.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W       = 32;
  localparam int ENG_FIELD_W = 8;
  localparam int EN_BIT      = 31;
  localparam int POWER_BIT   = 30;
  localparam int PIPE_BASE   = 16;
  localparam int PORT_BIT    = 20;
  localparam int MISC_BIT    = 22;
  localparam int SOUTH_BIT   = 23;
  // bits that never carry a source (reserved plus unassigned)
  localparam logic [REG_W-1:0] ZERO_MASK = 32'h3F28_FF00;
endpackage

// File: rtl/irq_eng_split.sv
module irq_eng_split #(
  parameter int ENG_WORDS = 4,
  parameter int HALF_W    = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENG_WORDS*2*HALF_W-1:0] eng_words,
  output logic [2*ENG_WORDS-1:0]        eng_sum_q
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int NSUM   = 2 * ENG_WORDS;

  logic [NSUM-1:0] eng_sum_d;

  for (genvar w = 0; w < ENG_WORDS; w++) begin : g_word
    for (genvar h = 0; h < 2; h++) begin : g_half
      always_comb
        eng_sum_d[2*w+h] = |eng_words[w*WORD_W + h*HALF_W +: HALF_W];

      assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> eng_sum_q[2*w+h] == $past(|eng_words[w*WORD_W + h*HALF_W +: HALF_W]))
        else $error("assert_eng_half_R4 word %0d half %0d", w, h);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eng_sum_q <= '0;
    else        eng_sum_q <= eng_sum_d;
  end
endmodule

// File: rtl/irq_disp_collect.sv
module irq_disp_collect
  import irq_agg_pkg::*;
#(
  parameter int NUM_PIPES = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PIPES-1:0] pipe_irq,
  input  logic                 port_irq,
  input  logic                 misc_irq,
  input  logic                 south_irq,
  input  logic                 power_irq,
  output logic [REG_W-1:0]     disp_src_q
);
  logic [REG_W-1:0] disp_src_d;

  always_comb begin
    disp_src_d            = '0;
    disp_src_d[PORT_BIT]  = port_irq;
    disp_src_d[MISC_BIT]  = misc_irq;
    disp_src_d[SOUTH_BIT] = south_irq;
    disp_src_d[POWER_BIT] = power_irq;
    for (int p = 0; p < NUM_PIPES; p++)
      disp_src_d[PIPE_BASE+p] = pipe_irq[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disp_src_q <= '0;
    else        disp_src_q <= disp_src_d;
  end

  assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> disp_src_q[POWER_BIT] == $past(power_irq))
    else $error("assert_power_line_R6");

  assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> disp_src_q[SOUTH_BIT] == $past(south_irq))
    else $error("assert_south_line_R5");
endmodule

// File: rtl/irq_master_ctl.sv
module irq_master_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic reg_we,
  input  logic wr_en_bit,
  input  logic src_any,
  output logic en_q,
  output logic host_irq
);
  logic en_d;
  logic en_ce;

  always_comb begin
    en_ce = reg_we;
    en_d  = wr_en_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= 1'b0;
    else if (en_ce) en_q <= en_d;
  end

  always_comb host_irq = en_q & src_any;

  assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> en_q == $past(wr_en_bit))
    else $error("assert_en_write_R2");

  assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(en_q))
    else $error("assert_en_hold_R2");
endmodule

// File: rtl/irq_master_agg.sv
module irq_master_agg
  import irq_agg_pkg::*;
#(
  parameter int ENG_WORDS = 4,   // 2*ENG_WORDS must not exceed ENG_FIELD_W
  parameter int HALF_W    = 16,
  parameter int NUM_PIPES = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [ENG_WORDS*2*HALF_W-1:0] eng_words,
  input  logic [NUM_PIPES-1:0]          pipe_irq,
  input  logic                          port_irq,
  input  logic                          misc_irq,
  input  logic                          south_irq,
  input  logic                          power_irq,
  input  logic                          reg_we,
  input  logic [REG_W-1:0]              reg_wdata,
  output logic [REG_W-1:0]              reg_rdata,
  output logic                          host_irq
);
  localparam int NSUM = 2 * ENG_WORDS;

  logic [NSUM-1:0]  eng_sum_q;
  logic [REG_W-1:0] disp_src_q;
  logic [REG_W-1:0] src_vec;
  logic             src_any;
  logic             en_q;

  irq_eng_split #(.ENG_WORDS(ENG_WORDS), .HALF_W(HALF_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_words (eng_words),
    .eng_sum_q (eng_sum_q)
  );

  irq_disp_collect #(.NUM_PIPES(NUM_PIPES)) u_disp (
    .clk        (clk),
    .rst_n      (rst_n),
    .pipe_irq   (pipe_irq),
    .port_irq   (port_irq),
    .misc_irq   (misc_irq),
    .south_irq  (south_irq),
    .power_irq  (power_irq),
    .disp_src_q (disp_src_q)
  );

  always_comb begin
    src_vec = disp_src_q;
    src_vec[NSUM-1:0] = eng_sum_q;
    src_vec[EN_BIT] = 1'b0;
    src_any = |src_vec;
  end

  irq_master_ctl u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .wr_en_bit (reg_wdata[EN_BIT]),
    .src_any   (src_any),
    .en_q      (en_q),
    .host_irq  (host_irq)
  );

  always_comb begin
    reg_rdata         = src_vec;
    reg_rdata[EN_BIT] = en_q;
  end

  assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ZERO_MASK) == '0)
    else $error("assert_zero_bits_R8");

  assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> (en_q && eng_sum_q != '0) || (en_q && disp_src_q != '0))
    else $error("assert_host_gate_R3");

  assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_wdata[EN_BIT]) |=> !host_irq)
    else $error("assert_host_drop_R10");

  assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_wdata[EN_BIT] && src_any && $stable(src_any)) |=> host_irq || !src_any)
    else $error("assert_host_rearm_R10");
endmodule

// File: tb/tb_irq_master_agg.sv
`timescale 1ns/1ps
module tb_irq_master_agg;
  localparam int ENG_WORDS = 4;
  localparam int HALF_W    = 16;
  localparam int NUM_PIPES = 3;
  localparam int EW        = ENG_WORDS * 2 * HALF_W;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [EW-1:0]   eng_words;
  logic [NUM_PIPES-1:0] pipe_irq;
  logic            port_irq, misc_irq, south_irq, power_irq;
  logic            reg_we;
  logic [31:0]     reg_wdata;
  logic [31:0]     reg_rdata;
  logic            host_irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_master_agg #(.ENG_WORDS(ENG_WORDS), .HALF_W(HALF_W), .NUM_PIPES(NUM_PIPES)) dut (
    .clk(clk), .rst_n(rst_n), .eng_words(eng_words), .pipe_irq(pipe_irq),
    .port_irq(port_irq), .misc_irq(misc_irq), .south_irq(south_irq),
    .power_irq(power_irq), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .host_irq(host_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_src();
    eng_words = '0; pipe_irq = '0;
    port_irq = 0; misc_irq = 0; south_irq = 0; power_irq = 0;
  endtask

  task automatic wr(logic [31:0] d);
    reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic t_reset();
    chk("R1 reset rdata", reg_rdata, 32'h0);
    chk("R1 reset host", {31'b0, host_irq}, 32'h0);
  endtask

  task automatic t_engine();
    for (int w = 0; w < ENG_WORDS; w++) begin
      for (int h = 0; h < 2; h++) begin
        clear_src();
        eng_words[w*32 + h*16 + 15] = 1'b1;
        tick();
        chk("R4 engine top bit of half", reg_rdata, 32'h1 << (2*w+h));
        clear_src();
        eng_words[w*32 + h*16] = 1'b1;
        tick();
        chk("R4 engine bottom bit of half", reg_rdata, 32'h1 << (2*w+h));
      end
    end
    clear_src();
    eng_words[31:0]   = 32'h0040_0000;
    eng_words[63:32]  = 32'h0000_0200;
    eng_words[127:96] = 32'h0000_8000;
    tick();
    chk("R4 blitter+video1+venh", reg_rdata, 32'h0000_0046);
  endtask

  task automatic t_display();
    for (int p = 0; p < NUM_PIPES; p++) begin
      clear_src(); pipe_irq[p] = 1'b1; tick();
      chk("R5 pipe", reg_rdata, 32'h1 << (16+p));
    end
    clear_src(); port_irq = 1; tick();
    chk("R5 port", reg_rdata, 32'h0010_0000);
    clear_src(); misc_irq = 1; tick();
    chk("R5 misc", reg_rdata, 32'h0040_0000);
    clear_src(); south_irq = 1; tick();
    chk("R5 south", reg_rdata, 32'h0080_0000);
    clear_src(); power_irq = 1; tick();
    chk("R6 power", reg_rdata, 32'h4000_0000);
    clear_src(); tick();
  endtask

  task automatic t_zero_bits();
    eng_words = '1; pipe_irq = '1;
    port_irq = 1; misc_irq = 1; south_irq = 1; power_irq = 1;
    tick();
    chk("R8 all inputs high", reg_rdata, 32'h40D7_00FF);
    chk("R8 zero field", reg_rdata & 32'h3F28_FF00, 32'h0);
    clear_src(); tick();
  endtask

  task automatic t_enable_rw();
    wr(32'h8000_0000);
    chk("R2 enable set", reg_rdata, 32'h8000_0000);
    tick(); tick();
    chk("R2 enable holds", reg_rdata, 32'h8000_0000);
    wr(32'h0000_0000);
    chk("R2 enable cleared", reg_rdata, 32'h0);
  endtask

  task automatic t_readonly();
    wr(32'h7FFF_FFFF);
    chk("R7 write to source bits no sources", reg_rdata, 32'h0);
    power_irq = 1; tick();
    wr(32'h3FFF_FFFF);
    chk("R7 power bit kept", reg_rdata, 32'h4000_0000);
    clear_src(); tick();
    chk("R7 source clears only from input", reg_rdata, 32'h0);
  endtask

  task automatic t_gate();
    wr(32'h8000_0000);
    chk("R3 enabled no source", {31'b0, host_irq}, 32'h0);
    pipe_irq[1] = 1; tick();
    chk("R3 enabled with source", {31'b0, host_irq}, 32'h1);
    clear_src(); tick();
    chk("R3 source gone", {31'b0, host_irq}, 32'h0);
    wr(32'h0);
    eng_words[0] = 1; tick();
    chk("R3 disabled with source", {31'b0, host_irq}, 32'h0);
    clear_src(); tick();
  endtask

  task automatic t_latency();
    misc_irq = 1;
    #5;
    chk("R9 before edge", reg_rdata, 32'h0);
    @(posedge clk); #1;
    chk("R9 after edge", reg_rdata, 32'h0040_0000);
    @(negedge clk);
    clear_src(); tick();
  endtask

  task automatic t_service();
    wr(32'h8000_0000);
    eng_words[40] = 1; south_irq = 1; tick();
    chk("R10 line up", {31'b0, host_irq}, 32'h1);
    wr(32'h0);
    chk("R10 line dropped", {31'b0, host_irq}, 32'h0);
    chk("R10 sources visible", reg_rdata, 32'h0080_0004);
    wr(32'h8000_0000);
    chk("R10 line back on pending", {31'b0, host_irq}, 32'h1);
    clear_src(); tick();
    chk("R10 line off after service", {31'b0, host_irq}, 32'h0);
    wr(32'h0);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_wdata = '0;
    clear_src();
    eng_words = '1; power_irq = 1;
    repeat (3) tick();
    chk("R1 in reset", reg_rdata, 32'h0);
    clear_src();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_engine();
    t_display();
    t_zero_bits();
    t_enable_rw();
    t_readonly();
    t_gate();
    t_latency();
    t_service();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule